// File: doc/BRIEF.md
# Parallel-Port Host State Front End

This block is the front end of a peripheral that hangs off a PC-style parallel port. The host cannot issue bus cycles. It drives a data byte and a control byte, and it reads back a status byte. The low four bits of the control byte form a 4-bit state code. The host clocks each transfer by moving that code from an idle value to an active value and then back to the same idle value. The block turns these code walks into single-cycle write strobes for two device paths: a sound microcontroller and an FM synthesizer. It also turns them into a read-acknowledge for the microcontroller's output byte.

The status byte works in two modes. In flag mode it shows the device handshake flags. When a read code is selected it shows one nibble of a device byte on the upper four lines. The current code also selects which busy flag appears on the WAIT line. One code holds the attached devices in reset. Four codes are invalid and are treated as inert.

All host inputs pass through a two-flop synchronizer before any edge detection. The device-side ports are simple request and acknowledge signals in the core clock domain.

Top module: `lpt_host_front`

## Requirements
- R1: The code walk 5h→7h→5h produces exactly one `snd_wr_o` pulse with `snd_cmd_o`=0. The walk 5h→Dh→5h produces exactly one pulse with `snd_cmd_o`=1.
- R2: The code walk 1h→9h→1h produces exactly one `fm_wr_o` pulse with `fm_index_o`=1. The walk 1h→3h→1h produces exactly one pulse with `fm_index_o`=0.
- R3: `wr_byte_o` takes the data byte present when the code enters the active value. A data change while the code stays active does not alter it.
- R4: No strobe is produced in these cases:
  - an active write code is entered from anything other than the write-idle code of its own path (1h for codes 3h and 9h; 5h for codes 7h and Dh);
  - the code moves from one active code to another;
  - the idle code that is returned to is not that matching write-idle code.
- R5: The invalid codes 2h, Ah, Bh and Eh never cause a strobe. They never change `wr_byte_o`, and entering one abandons a pending write.
- R6: For every code except 0h, 4h, 6h and 8h, the status byte is in flag mode:
  - bit 7 is WAIT;
  - bit 6 is `irq_req_i`;
  - bit 5 is set when control bits 7:5 are all 1;
  - bit 4 is `fifo_srq_i`;
  - bit 3 is `snd_dav_i`;
  - bits 2:0 are 0.
  The FM path has no influence on bit 3.
- R7: In flag mode, WAIT is `snd_wait_i` when code bit 2 is 1 and `fm_busy_i` when code bit 2 is 0.
- R8: Codes 4h and 0h put the low nibble of `snd_rd_byte_i` or `fm_stat_i` (respectively) on status bits 7:4. Codes 6h and 8h put the high nibble of the same bytes there. Bits 3:0 read 0 in these modes.
- R9: The code step 6h→4h produces exactly one `snd_rd_ack_o` pulse. No other step produces one.
- R10: `host_irq_o` equals `irq_req_i` AND control bit 4.
- R11: `dev_reset_o` is high exactly while the synchronized code is Fh. Code Fh clears `wr_byte_o` to 0 and cancels a pending write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_data_i | input | 8 | Host data lines |
| host_ctrl_i | input | 8 | Host control byte: bits 3:0 state code, bit 4 interrupt enable, bits 7:5 input select |
| host_status_o | output | 8 | Status byte returned to the host |
| host_irq_o | output | 1 | Interrupt request toward the host |
| snd_wait_i | input | 1 | Microcontroller cannot accept a byte |
| snd_dav_i | input | 1 | Microcontroller or FIFO has a byte for the host |
| snd_rd_byte_i | input | 8 | Byte offered to the host for reading |
| snd_rd_ack_o | output | 1 | One-cycle pulse: host finished reading the byte |
| snd_wr_o | output | 1 | One-cycle write strobe to the microcontroller |
| snd_cmd_o | output | 1 | Qualifies `snd_wr_o`: 1 command, 0 data |
| fifo_srq_i | input | 1 | FIFO service request |
| fm_busy_i | input | 1 | FM path is still clocking a previous write |
| fm_stat_i | input | 8 | FM status byte |
| fm_wr_o | output | 1 | One-cycle write strobe to the FM path |
| fm_index_o | output | 1 | Qualifies `fm_wr_o`: 1 index, 0 data |
| wr_byte_o | output | 8 | Latched write byte for either path |
| irq_req_i | input | 1 | Device interrupt pending |
| dev_reset_o | output | 1 | Reset to the attached devices |

## Verification
The bench walks every ordered pair of start code and target code. For each pair it forms the round trip start→target→start, with an invalid code as the separator. It predicts the strobe count, the write qualifier, the read acknowledge and the latched byte from the path rules alone. This exposes three classes of fault:
- a decoder that strobes on a mismatched idle code or on an invalid code;
- a decoder that latches on the return edge instead of the entry edge;
- a decoder that forgets to cancel on reset.

Directed cases then cover three further faults:
- data that changes mid-strobe, which catches a design that samples late;
- an active-to-active hop and an abort through the reset code, which catch a design with a sticky pending flag;
- the 6h→4h read step, which catches a missing or doubled acknowledge.

The status byte is checked over all combinations of the five flag inputs and the input-select field, under both write-idle codes. A swapped WAIT source, a shifted bit or a leaked FM flag shows up as a wrong byte. The nibble codes are checked with asymmetric bytes, so a swapped nibble or a wrong source device is visible.

// File: rtl/lpt_host_pkg.sv
package lpt_host_pkg;

    parameter int unsigned HP_DW = 8;

    typedef logic [3:0] code_t;

    localparam code_t K_FM_RD_IDLE  = 4'h0;
    localparam code_t K_FM_WR_IDLE  = 4'h1;
    localparam code_t K_FM_WR_DATA  = 4'h3;
    localparam code_t K_SND_RD_IDLE = 4'h4;
    localparam code_t K_SND_WR_IDLE = 4'h5;
    localparam code_t K_SND_RD_DATA = 4'h6;
    localparam code_t K_SND_WR_DATA = 4'h7;
    localparam code_t K_FM_RD_STAT  = 4'h8;
    localparam code_t K_FM_WR_INDEX = 4'h9;
    localparam code_t K_SND_RD_STAT = 4'hC;
    localparam code_t K_SND_WR_CMD  = 4'hD;
    localparam code_t K_DEV_RESET   = 4'hF;

    typedef struct packed {
        code_t             prev;
        logic              pend;
        logic [HP_DW-1:0]  wbyte;
        logic              snd_wr;
        logic              snd_cmd;
        logic              fm_wr;
        logic              fm_idx;
        logic              rd_ack;
        logic              dev_rst;
    } strobe_st_t;

    typedef struct packed {
        logic [HP_DW-1:0] status;
        logic             irq;
    } status_st_t;

    function automatic logic code_invalid(input code_t c);
        return (c == 4'h2) || (c == 4'hA) || (c == 4'hB) || (c == 4'hE);
    endfunction

    function automatic logic code_wr_active(input code_t c);
        return (c == K_FM_WR_DATA) || (c == K_FM_WR_INDEX) ||
               (c == K_SND_WR_DATA) || (c == K_SND_WR_CMD);
    endfunction

    function automatic logic code_wr_idle(input code_t c);
        return (c == K_FM_WR_IDLE) || (c == K_SND_WR_IDLE);
    endfunction

    function automatic logic code_nibble(input code_t c);
        return (c == K_FM_RD_IDLE) || (c == K_SND_RD_IDLE) ||
               (c == K_SND_RD_DATA) || (c == K_FM_RD_STAT);
    endfunction

endpackage

// File: rtl/lpt_host_sync.sv
module lpt_host_sync #(
    parameter int unsigned W      = 16,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_i;
        for (int k = 1; k < STAGES; k++) begin
            chain_d[k] = chain_q[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[LAST];

    initial begin
        assert (STAGES >= 2) else $error("synchronizer needs two or more stages");
    end
endmodule

// File: rtl/lpt_host_strobe.sv
module lpt_host_strobe
    import lpt_host_pkg::*;
#(
    parameter int unsigned DW = HP_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  code_t         code_i,
    input  logic [DW-1:0] data_i,
    output logic          snd_wr_o,
    output logic          snd_cmd_o,
    output logic          fm_wr_o,
    output logic          fm_index_o,
    output logic          rd_ack_o,
    output logic          dev_reset_o,
    output logic [DW-1:0] wr_byte_o
);
    strobe_st_t st_d, st_q;
    logic       same_path;

    assign same_path = (code_i[2] == st_q.prev[2]);

    always_comb begin
        st_d         = st_q;
        st_d.snd_wr  = 1'b0;
        st_d.fm_wr   = 1'b0;
        st_d.rd_ack  = 1'b0;
        st_d.dev_rst = (code_i == K_DEV_RESET);
        st_d.prev    = code_i;
        if (code_i != st_q.prev) begin
            st_d.pend = 1'b0;
            if (code_wr_active(code_i) && code_wr_idle(st_q.prev) && same_path) begin
                st_d.pend  = 1'b1;
                st_d.wbyte = data_i;
            end else if (code_wr_idle(code_i) && st_q.pend && same_path) begin
                if (code_i[2]) begin
                    st_d.snd_wr  = 1'b1;
                    st_d.snd_cmd = st_q.prev[3];
                end else begin
                    st_d.fm_wr  = 1'b1;
                    st_d.fm_idx = st_q.prev[3];
                end
            end
            if (st_q.prev == K_SND_RD_DATA && code_i == K_SND_RD_IDLE) begin
                st_d.rd_ack = 1'b1;
            end
        end
        if (code_i == K_DEV_RESET) begin
            st_d.pend  = 1'b0;
            st_d.wbyte = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign snd_wr_o    = st_q.snd_wr;
    assign snd_cmd_o   = st_q.snd_cmd;
    assign fm_wr_o     = st_q.fm_wr;
    assign fm_index_o  = st_q.fm_idx;
    assign rd_ack_o    = st_q.rd_ack;
    assign dev_reset_o = st_q.dev_rst;
    assign wr_byte_o   = st_q.wbyte;

    assert_snd_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        snd_wr_o |=> !snd_wr_o);
    assert_fm_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fm_wr_o |=> !fm_wr_o);
    assert_bad_code_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        code_invalid(code_i) |=> ($stable(wr_byte_o) && !snd_wr_o && !fm_wr_o));
    assert_reset_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (code_i == K_DEV_RESET) |=> (wr_byte_o == '0 && dev_reset_o));
    assert_ack_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack_o |=> !rd_ack_o);
endmodule

// File: rtl/lpt_host_status.sv
module lpt_host_status
    import lpt_host_pkg::*;
#(
    parameter int unsigned DW = HP_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  code_t         code_i,
    input  logic          irq_en_i,
    input  logic          par_en_i,
    input  logic          snd_wait_i,
    input  logic          fm_busy_i,
    input  logic          irq_req_i,
    input  logic          srq_i,
    input  logic          dav_i,
    input  logic [DW-1:0] snd_byte_i,
    input  logic [DW-1:0] fm_byte_i,
    output logic [DW-1:0] status_o,
    output logic          irq_o
);
    localparam int unsigned NW = DW / 2;

    status_st_t       so_d, so_q;
    logic [DW-1:0]    src_byte;
    logic [NW-1:0]    nib;
    logic             wait_flag;

    always_comb begin
        src_byte  = code_i[2] ? snd_byte_i : fm_byte_i;
        nib       = (code_i[1] | code_i[3]) ? src_byte[DW-1:NW] : src_byte[NW-1:0];
        wait_flag = code_i[2] ? snd_wait_i : fm_busy_i;
        so_d      = so_q;
        if (code_nibble(code_i)) begin
            so_d.status = {nib, {NW{1'b0}}};
        end else begin
            so_d.status = {wait_flag, irq_req_i, par_en_i, srq_i, dav_i, {(DW-5){1'b0}}};
        end
        so_d.irq = irq_req_i & irq_en_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) so_q <= '0;
        else        so_q <= so_d;
    end

    assign status_o = so_q.status;
    assign irq_o    = so_q.irq;

    assert_nibble_low_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        code_nibble(code_i) |=> (status_o[NW-1:0] == '0));
    assert_no_fm_dav_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!code_nibble(code_i) && !dav_i) |=> !status_o[3]);
    assert_irq_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en_i |=> !irq_o);
endmodule

// File: rtl/lpt_host_front.sv
module lpt_host_front
    import lpt_host_pkg::*;
#(
    parameter int unsigned DW          = HP_DW,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] host_data_i,
    input  logic [7:0]    host_ctrl_i,
    output logic [DW-1:0] host_status_o,
    output logic          host_irq_o,
    input  logic          snd_wait_i,
    input  logic          snd_dav_i,
    input  logic [DW-1:0] snd_rd_byte_i,
    output logic          snd_rd_ack_o,
    output logic          snd_wr_o,
    output logic          snd_cmd_o,
    input  logic          fifo_srq_i,
    input  logic          fm_busy_i,
    input  logic [DW-1:0] fm_stat_i,
    output logic          fm_wr_o,
    output logic          fm_index_o,
    output logic [DW-1:0] wr_byte_o,
    input  logic          irq_req_i,
    output logic          dev_reset_o
);
    localparam int unsigned SW = DW + 8;

    logic [SW-1:0] sync_bus;
    logic [DW-1:0] data_s;
    logic [7:0]    ctrl_s;
    code_t         code_s;
    logic          irq_en_s;
    logic          par_en_s;

    lpt_host_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i({host_ctrl_i, host_data_i}),
        .sync_o (sync_bus)
    );

    assign data_s   = sync_bus[DW-1:0];
    assign ctrl_s   = sync_bus[SW-1:DW];
    assign code_s   = ctrl_s[3:0];
    assign irq_en_s = ctrl_s[4];
    assign par_en_s = &ctrl_s[7:5];

    lpt_host_strobe #(.DW(DW)) u_strobe (
        .clk        (clk),
        .rst_n      (rst_n),
        .code_i     (code_s),
        .data_i     (data_s),
        .snd_wr_o   (snd_wr_o),
        .snd_cmd_o  (snd_cmd_o),
        .fm_wr_o    (fm_wr_o),
        .fm_index_o (fm_index_o),
        .rd_ack_o   (snd_rd_ack_o),
        .dev_reset_o(dev_reset_o),
        .wr_byte_o  (wr_byte_o)
    );

    lpt_host_status #(.DW(DW)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .code_i    (code_s),
        .irq_en_i  (irq_en_s),
        .par_en_i  (par_en_s),
        .snd_wait_i(snd_wait_i),
        .fm_busy_i (fm_busy_i),
        .irq_req_i (irq_req_i),
        .srq_i     (fifo_srq_i),
        .dav_i     (snd_dav_i),
        .snd_byte_i(snd_rd_byte_i),
        .fm_byte_i (fm_stat_i),
        .status_o  (host_status_o),
        .irq_o     (host_irq_o)
    );

    assert_one_path_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(snd_wr_o && fm_wr_o));
endmodule

// File: tb/lpt_host_front_tb.sv
`timescale 1ns/1ps
module lpt_host_front_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] host_data_i = '0;
    logic [7:0] host_ctrl_i = '0;
    logic [7:0] host_status_o;
    logic       host_irq_o;
    logic       snd_wait_i = 0, snd_dav_i = 0, fifo_srq_i = 0, fm_busy_i = 0, irq_req_i = 0;
    logic [7:0] snd_rd_byte_i = '0, fm_stat_i = '0;
    logic       snd_rd_ack_o, snd_wr_o, snd_cmd_o, fm_wr_o, fm_index_o, dev_reset_o;
    logic [7:0] wr_byte_o;

    always #2.5 clk = ~clk;

    lpt_host_front u_dut (
        .clk(clk), .rst_n(rst_n), .host_data_i(host_data_i), .host_ctrl_i(host_ctrl_i),
        .host_status_o(host_status_o), .host_irq_o(host_irq_o),
        .snd_wait_i(snd_wait_i), .snd_dav_i(snd_dav_i), .snd_rd_byte_i(snd_rd_byte_i),
        .snd_rd_ack_o(snd_rd_ack_o), .snd_wr_o(snd_wr_o), .snd_cmd_o(snd_cmd_o),
        .fifo_srq_i(fifo_srq_i), .fm_busy_i(fm_busy_i), .fm_stat_i(fm_stat_i),
        .fm_wr_o(fm_wr_o), .fm_index_o(fm_index_o), .wr_byte_o(wr_byte_o),
        .irq_req_i(irq_req_i), .dev_reset_o(dev_reset_o)
    );

    int n_chk = 0, n_fail = 0;
    int n_snd = 0, n_fm = 0, n_ack = 0;
    logic last_cmd = 0, last_idx = 0;

    always @(posedge clk) begin
        #1;
        if (snd_wr_o)     begin n_snd++; last_cmd = snd_cmd_o; end
        if (fm_wr_o)      begin n_fm++;  last_idx = fm_index_o; end
        if (snd_rd_ack_o) n_ack++;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic setc(input logic [3:0] c);
        @(negedge clk);
        host_ctrl_i[3:0] = c;
        repeat (4) @(negedge clk);
    endtask

    function automatic bit wr_idle(input int c);
        return c == 1 || c == 5;
    endfunction
    function automatic bit wr_act(input int c);
        return c == 3 || c == 9 || c == 7 || c == 13;
    endfunction
    function automatic bit pathmatch(input int idle, input int act);
        return wr_idle(idle) && wr_act(act) && (((idle >> 2) & 1) == ((act >> 2) & 1));
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] eb;
        int s0, f0, k0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // reset state
        chk(wr_byte_o == 0 && !snd_wr_o && !fm_wr_o, "R1 reset outputs", wr_byte_o, 0);
        chk(host_status_o == 0, "R8 reset status", host_status_o, 0);
        chk(!dev_reset_o && !host_irq_o, "R11 reset dev_reset", dev_reset_o, 0);

        // exhaustive sweep: start code i, target a, round trip i->a->i
        eb = 8'h00;
        for (int i = 0; i < 16; i++) begin
            for (int a = 0; a < 16; a++) begin
                logic [7:0] v;
                bit es, ef, ek;
                v = 8'((i * 16 + a) ^ 8'h5A);
                setc(4'h2);
                host_data_i = v;
                s0 = n_snd; f0 = n_fm; k0 = n_ack;
                setc(4'(i));
                if (i == 15) eb = 8'h00;
                setc(4'(a));
                if (a == 15) eb = 8'h00;
                else if (pathmatch(i, a)) eb = v;
                setc(4'(i));
                if (i == 15) eb = 8'h00;
                else if (pathmatch(a, i)) eb = v;
                es = pathmatch(i, a) && (i == 5);
                ef = pathmatch(i, a) && (i == 1);
                ek = (i == 4 && a == 6) || (i == 6 && a == 4);
                chk(n_snd - s0 == int'(es), $sformatf("R1/R4/R5 snd strobes %0h->%0h", i, a), n_snd - s0, int'(es));
                chk(n_fm - f0 == int'(ef), $sformatf("R2/R4/R5 fm strobes %0h->%0h", i, a), n_fm - f0, int'(ef));
                chk(n_ack - k0 == int'(ek), $sformatf("R9 ack %0h->%0h", i, a), n_ack - k0, int'(ek));
                chk(wr_byte_o == eb, $sformatf("R3/R5/R11 byte %0h->%0h", i, a), wr_byte_o, eb);
                if (es) chk(last_cmd == (a == 13), "R1 cmd qualifier", last_cmd, int'(a == 13));
                if (ef) chk(last_idx == (a == 9), "R2 index qualifier", last_idx, int'(a == 9));
            end
        end

        // R3: data change during active code is ignored
        setc(4'h5); host_data_i = 8'h3C;
        setc(4'h7); host_data_i = 8'hC3;
        repeat (3) @(negedge clk);
        s0 = n_snd;
        setc(4'h5);
        chk(n_snd - s0 == 1 && wr_byte_o == 8'h3C, "R3 late data change", wr_byte_o, 8'h3C);

        // R4: active to active hop, no strobe
        s0 = n_snd;
        setc(4'h7); setc(4'hD); setc(4'h5);
        chk(n_snd == s0, "R4 active-to-active", n_snd - s0, 0);

        // R5: abandon through invalid code, byte kept
        host_data_i = 8'h77;
        setc(4'h1); setc(4'h9); host_data_i = 8'h11; setc(4'hA);
        f0 = n_fm;
        setc(4'h1);
        chk(n_fm == f0 && wr_byte_o == 8'h77, "R5 invalid abandons write", wr_byte_o, 8'h77);

        // R11: reset code cancels and clears
        host_data_i = 8'h99;
        setc(4'h5); setc(4'h7);
        @(negedge clk);
        host_ctrl_i[3:0] = 4'hF;
        repeat (4) @(negedge clk);
        chk(dev_reset_o == 1'b1, "R11 dev_reset during reset code", dev_reset_o, 1);
        chk(wr_byte_o == 8'h00, "R11 byte cleared", wr_byte_o, 0);
        s0 = n_snd;
        setc(4'h5);
        chk(dev_reset_o == 1'b0 && n_snd == s0, "R11 no strobe after reset", n_snd - s0, 0);

        // R8: nibble codes
        snd_rd_byte_i = 8'hA5; fm_stat_i = 8'h3E;
        setc(4'h4); chk(host_status_o == 8'h50, "R8 snd low nibble", host_status_o, 8'h50);
        setc(4'h6); chk(host_status_o == 8'hA0, "R8 snd high nibble", host_status_o, 8'hA0);
        setc(4'h0); chk(host_status_o == 8'hE0, "R8 fm low nibble", host_status_o, 8'hE0);
        setc(4'h8); chk(host_status_o == 8'h30, "R8 fm high nibble", host_status_o, 8'h30);

        // R6/R7: flag mode sweep under both write idles and read-status code
        for (int ci = 0; ci < 3; ci++) begin
            logic [3:0] c;
            c = (ci == 0) ? 4'h5 : (ci == 1) ? 4'h1 : 4'hC;
            setc(c);
            for (int v = 0; v < 64; v++) begin
                logic [7:0] exp;
                bit w;
                @(negedge clk);
                snd_wait_i = v[0]; fm_busy_i = v[1]; irq_req_i = v[2];
                fifo_srq_i = v[3]; snd_dav_i = v[4];
                host_ctrl_i[7:5] = v[5] ? 3'b111 : 3'b011;
                repeat (4) @(negedge clk);
                w = c[2] ? v[0] : v[1];
                exp = {w, v[2], v[5], v[3], v[4], 3'b000};
                chk(host_status_o == exp, $sformatf("R6/R7 flags code %0h v=%0d", c, v), host_status_o, exp);
            end
        end

        // R10: interrupt gating
        @(negedge clk); irq_req_i = 1; host_ctrl_i[4] = 1;
        repeat (4) @(negedge clk);
        chk(host_irq_o == 1'b1, "R10 irq enabled", host_irq_o, 1);
        @(negedge clk); host_ctrl_i[4] = 0;
        repeat (4) @(negedge clk);
        chk(host_irq_o == 1'b0, "R10 irq masked", host_irq_o, 0);
        @(negedge clk); irq_req_i = 0; host_ctrl_i[4] = 1;
        repeat (4) @(negedge clk);
        chk(host_irq_o == 1'b0, "R10 no request", host_irq_o, 0);

        summary();
        $finish;
    end
endmodule